// File: doc/BRIEF.md
# Four-lane idle and delimiter column encoder

This block sits on the transmit path between a 32-bit parallel packet interface (four bytes, each with its own control flag) and four per-lane 8B/10B encoders. Every cycle it turns one input column into one output column of four lane characters. Each character is an 8-bit value plus a control flag. Byte n always travels on lane n, so the lanes stay column-aligned.

The encoder handles gaps and delimiters:
- **Gaps.** An input column made entirely of idle codes is replaced by a lane idle pattern. The pattern is identical on every lane. It opens each gap with an alignment column and repeats the alignment column every sixteenth gap column.
- **Delimiters.** Start, terminate and error codes are converted to their line control characters.
- **Padding.** Idle bytes that share a column with packet traffic are sent as the sync character.
- **Bad codes.** Illegal or undefined control bytes become the error character.

The output is registered, with one cycle of latency.

Top module: `xgmii_lane_striper`

## Requirements
- R1: A byte whose control flag is 0 is sent on the lane of the same index, one cycle later, with the same value and output control flag 0. Input byte n is bits 8n+7 down to 8n, and its flag is bit n.
- R2: While synchronous reset is high, every lane outputs the alignment character 0x7C with control flag 1. After reset, the idle sequence continues from position 1, so the first all-idle column gives the sync character 0xBC.
- R3: An all-idle input column (every flag 1, every byte 0x07) that follows any other column is output one cycle later as 0x7C on all four lanes, with control flags 1.
- R4: Within a gap, the column at gap position p (counting from 0 at the gap's first column) is sent on all lanes, with control flags 1, as follows:
  - 0x7C when p mod 16 is 0;
  - 0xBC when p is odd;
  - 0x1C otherwise.
- R5: Control byte 0xFB (start) on lane 0 is sent as 0xFB with control 1. On lanes 1 to 3 it is sent as 0xFE with control 1.
- R6: Control byte 0xFD (terminate) is sent as 0xFD with control 1. Any idle control byte (0x07) in a column that is not all idle is sent as 0xBC with control 1. No output control character is ever 0x07.
- R7: Control byte 0xFE is sent as 0xFE with control 1. Any other control byte with no defined meaning is also sent as 0xFE with control 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_data | input | 32 | Input column; byte n belongs to lane n |
| col_ctl | input | 4 | Per-byte control flags; bit n for byte n |
| lane_data | output | 32 | Lane characters; bits 8n+7:8n for lane n |
| lane_ctl | output | 4 | Control flag of each lane character |

## Verification
The assertions assume that inputs hold known values at each rising edge. They also assume that reset is held for at least one edge before the first column of interest, because the gap-start and pass-through properties look one cycle into the past. The bench changes inputs only on falling edges and keeps reset high across an edge before releasing it. The table of columns covers every control code in lanes where it is both legal and illegal, and the long directed gap crosses the sixteen-column alignment boundary.

// File: rtl/xgmii_lane_striper.sv
module xgmii_lane_striper #(
  parameter int LANES        = 4,
  parameter int ALIGN_PERIOD = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [8*LANES-1:0]   col_data,
  input  logic [LANES-1:0]     col_ctl,
  output logic [8*LANES-1:0]   lane_data,
  output logic [LANES-1:0]     lane_ctl
);
  localparam int W  = 8 * LANES;
  localparam int CW = $clog2(ALIGN_PERIOD);

  localparam logic [7:0] IN_IDLE = 8'h07;
  localparam logic [7:0] CH_A    = 8'h7C;
  localparam logic [7:0] CH_K    = 8'hBC;
  localparam logic [7:0] CH_R    = 8'h1C;
  localparam logic [7:0] CH_S    = 8'hFB;
  localparam logic [7:0] CH_T    = 8'hFD;
  localparam logic [7:0] CH_E    = 8'hFE;

  logic [CW-1:0] gap_pos;
  logic          col_idle;
  logic [7:0]    idle_ch;
  logic [W-1:0]  nxt_data;

  always_comb begin
    col_idle = &col_ctl;
    for (int l = 0; l < LANES; l++)
      if (col_data[8*l +: 8] != IN_IDLE) col_idle = 1'b0;
  end

  assign idle_ch = (gap_pos == '0) ? CH_A : (gap_pos[0] ? CH_K : CH_R);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] b;
      b = col_data[8*l +: 8];
      if (col_idle)        nxt_data[8*l +: 8] = idle_ch;
      else if (!col_ctl[l]) nxt_data[8*l +: 8] = b;
      else begin
        case (b)
          IN_IDLE: nxt_data[8*l +: 8] = CH_K;
          CH_S:    nxt_data[8*l +: 8] = (l == 0) ? CH_S : CH_E;
          CH_T:    nxt_data[8*l +: 8] = CH_T;
          default: nxt_data[8*l +: 8] = CH_E;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_data <= {LANES{CH_A}};
      lane_ctl  <= '1;
      gap_pos   <= CW'(1);
    end else begin
      lane_data <= nxt_data;
      lane_ctl  <= col_idle ? '1 : col_ctl;
      if (!col_idle)                                   gap_pos <= '0;
      else if (gap_pos == CW'(ALIGN_PERIOD - 1))       gap_pos <= '0;
      else                                             gap_pos <= gap_pos + CW'(1);
    end
  end

  p_gap_start_align_r3: assert property (@(posedge clk) disable iff (rst)
    (!col_idle ##1 col_idle) |=> (lane_ctl == '1 && lane_data == {LANES{CH_A}}));

  p_idle_uniform_r4: assert property (@(posedge clk) disable iff (rst)
    col_idle |=> (lane_ctl == '1 && lane_data == {LANES{lane_data[7:0]}}));

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_chk
      p_data_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !col_ctl[g] |=> (!lane_ctl[g] && lane_data[8*g +: 8] == $past(col_data[8*g +: 8])));

      p_no_raw_idle_r6: assert property (@(posedge clk) disable iff (rst)
        lane_ctl[g] |-> lane_data[8*g +: 8] != IN_IDLE);

      p_terminate_r6: assert property (@(posedge clk) disable iff (rst)
        (col_ctl[g] && col_data[8*g +: 8] == CH_T) |=> (lane_ctl[g] && lane_data[8*g +: 8] == CH_T));

      if (g > 0) begin : g_nostart
        p_start_lane0_r5: assert property (@(posedge clk) disable iff (rst)
          (col_ctl[g] && col_data[8*g +: 8] == CH_S) |=> (lane_ctl[g] && lane_data[8*g +: 8] == CH_E));
      end
    end
  endgenerate
endmodule

// File: tb/xgmii_lane_striper_test.sv
module xgmii_lane_striper_test;
  localparam int PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] col_data = 32'h07070707;
  logic [3:0]  col_ctl = 4'hF;
  logic [31:0] lane_data;
  logic [3:0]  lane_ctl;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  xgmii_lane_striper uut (
    .clk(clk), .rst(rst), .col_data(col_data), .col_ctl(col_ctl),
    .lane_data(lane_data), .lane_ctl(lane_ctl)
  );

  always #(PERIOD/2) clk = ~clk;

  localparam logic [31:0] IDL = 32'h07070707;
  localparam logic [71:0] VEC [NV] = '{
    {IDL,          4'hF, 32'hBCBCBCBC, 4'hF},
    {IDL,          4'hF, 32'h1C1C1C1C, 4'hF},
    {32'h776655FB, 4'h1, 32'h776655FB, 4'h1},
    {32'h04030201, 4'h0, 32'h04030201, 4'h0},
    {32'h07FDAABB, 4'hC, 32'hBCFDAABB, 4'hC},
    {IDL,          4'hF, 32'h7C7C7C7C, 4'hF},
    {IDL,          4'hF, 32'hBCBCBCBC, 4'hF},
    {IDL,          4'hF, 32'h1C1C1C1C, 4'hF},
    {32'hFE00FB12, 4'hE, 32'hFEFEFE12, 4'hE},
    {IDL,          4'hF, 32'h7C7C7C7C, 4'hF},
    {32'h070707FD, 4'hF, 32'hBCBCBCFD, 4'hF},
    {IDL,          4'hF, 32'h7C7C7C7C, 4'hF}
  };

  task automatic check(input string req, input logic [31:0] ed, input logic [3:0] ec);
    checks++;
    if (lane_data !== ed || lane_ctl !== ec) begin
      fails++;
      $display("FAIL %s: got data=%h ctl=%h, expected data=%h ctl=%h", req, lane_data, lane_ctl, ed, ec);
    end
  endtask

  task automatic step(input logic [31:0] d, input logic [3:0] c);
    col_data = d;
    col_ctl = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R2 reset column", 32'h7C7C7C7C, 4'hF);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][71:40], VEC[i][39:36]);
      check($sformatf("R1/R3/R4/R5/R6/R7 vector %0d", i), VEC[i][35:4], VEC[i][3:0]);
    end

    for (int p = 1; p <= 36; p++) begin
      logic [7:0] ch;
      ch = (p % 16 == 0) ? 8'h7C : ((p % 2 == 1) ? 8'hBC : 8'h1C);
      step(IDL, 4'hF);
      check($sformatf("R4 gap position %0d", p), {4{ch}}, 4'hF);
    end

    step(32'hDEADBEEF, 4'h0);
    check("R1 lane mapping", 32'hDEADBEEF, 4'h0);
    step(32'hFB3C07FD, 4'hF);
    check("R5 R6 R7 mixed codes", 32'hFEFEBCFD, 4'hF);
    step(IDL, 4'hF);
    check("R3 gap start after mixed", 32'h7C7C7C7C, 4'hF);

    rst = 1'b1;
    step(32'h11223344, 4'h0);
    check("R2 reset mid-stream", 32'h7C7C7C7C, 4'hF);
    rst = 1'b0;
    step(IDL, 4'hF);
    check("R2 first idle after reset", 32'hBCBCBCBC, 4'hF);
    step(IDL, 4'hF);
    check("R2 R4 second idle after reset", 32'h1C1C1C1C, 4'hF);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule